// File: doc/BRIEF.md
# Burst-Capable Strobe-Handshake Register Bus Slave

This block connects an external asynchronous microprocessor bus of the address-strobe / data-strobe kind to a small internal byte-wide register array. All bus controls are synchronised into the system clock domain, and the block reacts to the strobe edges it detects there. An address is captured once, when the address strobe returns high while chip select is held low. From then on every data-strobe transfer reads or writes one byte. Each transfer is confirmed on an active-low data-acknowledge output.

The block supports burst access. The first transfer after the address is captured uses that address. Each later transfer, made without a new address strobe, uses the next address up. The 11-bit pointer wraps from the top of the space back to zero. The burst ends when chip select is released or when the address strobe falls again. Read data leaves the block on a separate output bus with an enable, so the pad ring can build the tri-state driver.

Top module: `mbus_burst_slave`

## Requirements
- R1: After reset, dtack_n is high, data_oe is low and every array entry holds 0x00.
- R2: While cs_n is low, a rising edge on as_n latches addr into the transfer pointer and opens a burst. The first transfer of that burst accesses that address.
- R3: dtack_n goes low exactly four clk rising edges after the first edge that samples ds_n low. This is two synchroniser stages plus two cycles of wait.
- R4: During a read (rw = 1), data_oe is high and data_o holds the addressed byte from the wait cycles until release. During a write (rw = 0), data_oe stays low.
- R5: During a write, data_i is stored into the addressed entry on the same edge that drives dtack_n low.
- R6: After ds_n returns high, dtack_n goes high and data_oe goes low together, exactly three clk edges later.
- R7: Each completed transfer advances the pointer by one. The next transfer in the same burst, made without a new address strobe, accesses the next address.
- R8: The pointer wraps from 0x7FF to 0x000. The array entry used is given by the low log2(DEPTH) bits of the pointer, with DEPTH = 32 by default.
- R9: A falling as_n or a high cs_n ends the burst. Data strobes that arrive before the next address capture get no dtack_n, do not drive data_oe and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| addr | input | 11 | Address, captured at the rising edge of as_n |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data toward the bus |
| data_oe | output | 1 | Output enable for data_o |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The hardest situation to reach is a data strobe that arrives after a burst has been closed but before a new address has been captured. It must be ignored without any side effect. The stimulus drops as_n and holds it low, or pulses cs_n high, in the middle of a burst, and then issues a write strobe. The bench checks that dtack_n never responds. It then captures a new address at the same location and reads the byte back to confirm the write was discarded. The pointer wrap is reached by capturing 0x7FF and writing two bytes in one burst.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} cyc_state_t;

  // next burst location, wrapping at the top of the address space
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  // array slot selected by a bus address
  function automatic int unsigned slot_of(input logic [ADDR_W-1:0] a, input int unsigned depth);
    return int'(a) % depth;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbus_cycle_fsm.sv
module mbus_cycle_fsm
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_s,
  input  logic              cs_s,
  input  logic              ds_s,
  input  logic              rw_s,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ptr,
  output logic              ds_fall,
  output logic              burst_on,
  output logic              ptr_step,
  output logic              wr_en,
  output logic              rd_drive,
  output logic              ack_on
);
  cyc_state_t state;
  logic as_prev, ds_prev, rw_q;
  logic as_rise, as_fall, kill, bus_evt;

  assign as_rise  = as_s & ~as_prev;
  assign as_fall  = ~as_s & as_prev;
  assign ds_fall  = ~ds_s & ds_prev;
  assign kill     = cs_s | as_fall;
  assign bus_evt  = kill | as_rise;
  assign wr_en    = (state == ST_WAIT) & ~ds_s & ~rw_q & ~bus_evt;
  assign ptr_step = (state == ST_ACK) & ds_s & ~bus_evt;
  assign rd_drive = rw_q & (state != ST_IDLE);
  assign ack_on   = (state == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      as_prev  <= 1'b1;
      ds_prev  <= 1'b1;
      rw_q     <= 1'b1;
      burst_on <= 1'b0;
      ptr      <= '0;
    end else begin
      as_prev <= as_s;
      ds_prev <= ds_s;
      if (kill) begin
        burst_on <= 1'b0;
        state    <= ST_IDLE;
      end else if (as_rise) begin
        burst_on <= 1'b1;
        ptr      <= addr;
        state    <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (ds_fall && burst_on) begin
            state <= ST_WAIT;
            rw_q  <= rw_s;
          end
          ST_WAIT: state <= ds_s ? ST_IDLE : ST_ACK;
          ST_ACK: if (ds_s) begin
            state <= ST_IDLE;
            ptr   <= addr_step(ptr);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs
  import mbus_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx   = IDX_W'(slot_of(ptr, DEPTH));
  assign rdata = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/mbus_burst_slave.sv
module mbus_burst_slave
  import mbus_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              ds_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              dtack_n
);
  logic [3:0]        ctl_s;
  logic              as_s, cs_s, ds_s, rw_s;
  logic [ADDR_W-1:0] ptr;
  logic              ds_fall, burst_on, ptr_step, wr_en, rd_drive, ack_on;
  logic [DATA_W-1:0] rdata;

  mbus_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({as_n, cs_n, ds_n, rw}),
    .q(ctl_s)
  );
  assign {as_s, cs_s, ds_s, rw_s} = ctl_s;

  mbus_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .as_s(as_s), .cs_s(cs_s), .ds_s(ds_s), .rw_s(rw_s), .addr(addr),
    .ptr(ptr), .ds_fall(ds_fall), .burst_on(burst_on), .ptr_step(ptr_step),
    .wr_en(wr_en), .rd_drive(rd_drive), .ack_on(ack_on)
  );

  mbus_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr),
    .wdata(data_i), .rdata(rdata)
  );

  assign data_o  = rd_drive ? rdata : '0;
  assign data_oe = rd_drive;
  assign dtack_n = ~ack_on;
endmodule

// File: rtl/mbus_burst_chk.sv
module mbus_burst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dtack_n,
  input logic        data_oe,
  input logic        ds_fall,
  input logic        ds_s,
  input logic        burst_on,
  input logic        ptr_step,
  input logic [10:0] ptr,
  input logic        wr_en
);
  // R3
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(ds_fall, 2));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> $past(!ds_s));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |-> (dtack_n && !data_oe));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> ((ptr - $past(ptr)) == 11'd1));

  // R5
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dtack_n);

  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(ds_fall));
endmodule

bind mbus_burst_slave mbus_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dtack_n(dtack_n), .data_oe(data_oe),
  .ds_fall(ds_fall), .ds_s(ds_s), .burst_on(burst_on),
  .ptr_step(ptr_step), .ptr(ptr), .wr_en(wr_en)
);

// File: tb/tb_mbus_burst_slave.sv
`timescale 1ns/1ps
module tb_mbus_burst_slave;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_n = 1'b1, cs_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe, dtack_n;

  int tests = 0;
  int fails = 0;
  logic [7:0] shadow [DEPTH];

  always #2 clk = ~clk;

  mbus_burst_slave #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rw(rw),
    .ds_n(ds_n), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .dtack_n(dtack_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic open_burst(input logic [10:0] a);
    cs_n = 1'b0; as_n = 1'b0; addr = a;
    cyc(3);
    as_n = 1'b1;
    cyc(5);
  endtask

  task automatic close_burst();
    cs_n = 1'b1; as_n = 1'b1;
    cyc(5);
  endtask

  // one data-strobe transfer; returns handshake timing and read data
  task automatic xfer(input bit rd, input logic [7:0] wd, output bit ack,
                      output int lat, output logic [7:0] rdat, output bit oe,
                      output int rel);
    rw = rd; data_i = wd; ds_n = 1'b0;
    ack = 0; lat = 0; rel = 0; rdat = '0; oe = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1); lat++;
      if (!dtack_n) begin ack = 1; break; end
    end
    if (ack) begin rdat = data_o; oe = data_oe; end
    ds_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1); rel++;
      if (dtack_n && !data_oe) break;
    end
    cyc(2);
  endtask

  task automatic wr_byte(input logic [10:0] a, input logic [7:0] v, input string tag);
    bit ack, oe; int lat, rel; logic [7:0] r;
    xfer(1'b0, v, ack, lat, r, oe, rel);
    check(ack, tag, ack, 1);
    check(!oe, {tag, " R4 no drive on write"}, oe, 0);
    if (ack) shadow[a % DEPTH] = v;
  endtask

  task automatic rd_byte(input logic [10:0] a, input string tag);
    bit ack, oe; int lat, rel; logic [7:0] r;
    xfer(1'b1, 8'h00, ack, lat, r, oe, rel);
    check(ack && oe, {tag, " R4 drive"}, {ack, oe}, 3);
    check(r == shadow[a % DEPTH], tag, r, shadow[a % DEPTH]);
  endtask

  task automatic t_reset();
    check(dtack_n === 1'b1, "R1 dtack_n idle", dtack_n, 1);
    check(data_oe === 1'b0, "R1 data_oe idle", data_oe, 0);
    open_burst(11'h010);
    rd_byte(11'h010, "R1 R2 reset content");
    rd_byte(11'h011, "R1 reset content next");
    close_burst();
  endtask

  task automatic t_timing();
    bit ack, oe; int lat, rel; logic [7:0] r;
    open_burst(11'h001);
    xfer(1'b0, 8'h5A, ack, lat, r, oe, rel);
    shadow[1] = 8'h5A;
    check(lat == 4, "R3 write ack latency", lat, 4);
    check(rel == 3, "R6 write release", rel, 3);
    xfer(1'b1, 8'h00, ack, lat, r, oe, rel);
    check(lat == 4, "R3 read ack latency", lat, 4);
    check(rel == 3, "R6 read release", rel, 3);
    close_burst();
  endtask

  task automatic t_burst();
    open_burst(11'h005);
    wr_byte(11'h005, 8'hC1, "R5 burst write 0");
    wr_byte(11'h006, 8'hC2, "R7 burst write 1");
    wr_byte(11'h007, 8'hC3, "R7 burst write 2");
    close_burst();
    open_burst(11'h005);
    rd_byte(11'h005, "R5 R2 readback 0");
    rd_byte(11'h006, "R7 readback 1");
    rd_byte(11'h007, "R7 readback 2");
    close_burst();
    open_burst(11'h006);
    rd_byte(11'h006, "R2 start mid");
    close_burst();
  endtask

  task automatic t_wrap();
    open_burst(11'h7FF);
    wr_byte(11'h7FF, 8'h9E, "R8 write top");
    wr_byte(11'h000, 8'h3D, "R8 write wrapped");
    close_burst();
    open_burst(11'h000);
    rd_byte(11'h000, "R8 wrapped at 0x000");
    close_burst();
    open_burst(11'h01F);
    rd_byte(11'h7FF, "R8 alias of 0x7FF");
    close_burst();
  endtask

  task automatic expect_ignored(input string tag);
    bit seen = 0;
    rw = 1'b0; data_i = 8'hEE; ds_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (!dtack_n || data_oe) seen = 1;
    end
    ds_n = 1'b1;
    cyc(4);
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_end();
    open_burst(11'h002);
    wr_byte(11'h002, 8'h11, "R9 setup write");
    as_n = 1'b0;
    cyc(4);
    expect_ignored("R9 strobe after as_n fall");
    close_burst();
    open_burst(11'h002);
    rd_byte(11'h002, "R9 earlier write kept");
    rd_byte(11'h003, "R9 no write after as_n fall");
    close_burst();
    open_burst(11'h008);
    cs_n = 1'b1; cyc(4); cs_n = 1'b0; cyc(4);
    expect_ignored("R9 strobe after cs_n release");
    close_burst();
    open_burst(11'h008);
    rd_byte(11'h008, "R9 no write after cs_n release");
    close_burst();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_timing();
    t_burst();
    t_wrap();
    t_end();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule